// File: doc/BRIEF.md
# Double-Buffered Eight-Channel Converter Code Bank

This block holds the digital codes for eight converter channels in two banks of registers. A staging bank takes the codes as they arrive, and a live bank drives the converter. Codes arrive on a write stream that carries a channel number and a 12-bit code. The stream has a valid/ready handshake, but the block never applies back-pressure: `wr_ready` stays high whenever the block is out of reset, so every cycle in which `wr_valid` is high counts as a completed write.

Copying from the staging bank to the live bank is called a load. A load can come from three sources: an active-low external pin, a two-bit mode that can make the live bank permanently transparent, or a one-shot update request. Each channel keeps a dirty flag, and a load copies only the channels whose staging register was written since that channel's last copy. A clear strobe zeroes both banks.

Top module: `dac_bank_dbuf`

## Requirements
- R1: After reset both banks hold zero, so every `dac_codes` field reads 0 and no channel is dirty.
- R2: With `load_mode` = 2'b00 the live bank is transparent. A write accepted at a clock edge appears on its channel's output field at that same edge.
- R3: With `load_mode` = 2'b01 (latched) and the pin high, written codes do not reach the outputs.
- R4: `load_n_pin` passes through a two-flop synchronizer. If the pin is low at edge k, the dirty channels are copied at edge k+2.
- R5: With `load_mode` = 2'b10, a rising edge on `single_update` triggers exactly one load, at the edge that samples the rise. If the request is held high, no further load occurs.
- R6: `load_mode` = 2'b11 is reserved. It triggers no internal load, so writes stay staged until the pin loads them.
- R7: A load copies only dirty channels and clears their dirty flags. A channel that is not dirty keeps its output.
- R8: If a write and a load happen on the same edge for the same channel, the newly written code reaches that channel's output on that edge.
- R9: A `data_clr` pulse zeroes both banks and all dirty flags at the next edge. A later load then leaves every output at 0.
- R10: `wr_ready` is high whenever `rst_n` is high, so the block never stalls the write stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Write stream valid |
| wr_ready | output | 1 | Write stream ready (always high out of reset) |
| wr_chan | input | 3 | Channel addressed by the write |
| wr_code | input | 12 | Code written to the staging register |
| load_n_pin | input | 1 | Asynchronous active-low external load pin |
| load_mode | input | 2 | 00 transparent, 01 latched, 10 one-shot, 11 reserved |
| single_update | input | 1 | Request for one load in one-shot mode (rising edge) |
| data_clr | input | 1 | Zeroes both banks and the dirty flags |
| dac_codes | output | 96 | Live codes, channel i at bits [12*i+11:12*i] |

## Verification
Each result has a fixed latency. A transparent or same-edge write is visible one edge after it is driven. A one-shot load is also visible one edge after the rising request. A clear takes effect on the next edge. A pin load appears three edges after the pin is driven low, because the pin must cross both synchronizer flops and then the live register.

The driver tags every expected code with the cycle in which it is due. The monitor samples at the falling edge of that cycle and compares. Codes that must not move are also checked several cycles later, after the stimulus that could have disturbed them.

// File: rtl/dacb_pkg.sv
package dacb_pkg;
  localparam int NCH   = 8;
  localparam int CW    = 12;
  localparam int CHW   = $clog2(NCH);

  typedef enum logic [1:0] {
    LM_TRANSP  = 2'b00,
    LM_LATCH   = 2'b01,
    LM_ONESHOT = 2'b10,
    LM_RSVD    = 2'b11
  } load_mode_e;
endpackage

// File: rtl/dacb_sync.sv
module dacb_sync #(
  parameter int   STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d_async};
  end

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/dacb_load_ctrl.sv
module dacb_load_ctrl
  import dacb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       single_req,
  input  logic       pin_n_sync,
  output logic       load
);
  logic req_q;
  logic shot;
  logic internal_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= single_req;
  end

  // one-shot: only on the rising edge of the request
  assign shot = (mode == LM_ONESHOT) && single_req && !req_q;

  always_comb begin
    unique case (load_mode_e'(mode))
      LM_TRANSP:  internal_load = 1'b1;
      LM_ONESHOT: internal_load = shot;
      default:    internal_load = 1'b0;
    endcase
  end

  assign load = internal_load || !pin_n_sync;

  assert_one_shot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    shot |=> !shot);
  assert_rsvd_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11 && pin_n_sync) |-> !load);
endmodule

// File: rtl/dacb_channel.sv
module dacb_channel #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_hit,
  input  logic [CW-1:0] wr_code,
  input  logic          load,
  output logic [CW-1:0] out_code
);
  logic [CW-1:0] in_q, in_nx, out_q;
  logic          pend_q, pend_nx;

  assign in_nx   = wr_hit ? wr_code : in_q;
  assign pend_nx = wr_hit || pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q   <= '0;
      out_q  <= '0;
      pend_q <= 1'b0;
    end else if (clr) begin
      in_q   <= '0;
      out_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      in_q <= in_nx;
      if (load && pend_nx) begin
        out_q  <= in_nx;
        pend_q <= 1'b0;
      end else begin
        pend_q <= pend_nx;
      end
    end
  end

  assign out_code = out_q;

  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !clr) |=> $stable(out_code));
  assert_same_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load && wr_hit && !clr) |=> (out_code == $past(wr_code)));
  assert_clean_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !pend_q && !wr_hit && !clr) |=> $stable(out_code));
  assert_pend_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> !pend_q);
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (out_code == '0 && in_q == '0 && !pend_q));
endmodule

// File: rtl/dac_bank_dbuf.sv
module dac_bank_dbuf
  import dacb_pkg::*;
#(
  parameter int N_CH   = NCH,
  parameter int CODE_W = CW,
  localparam int ADDR_W = $clog2(N_CH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_valid,
  output logic                     wr_ready,
  input  logic [ADDR_W-1:0]        wr_chan,
  input  logic [CODE_W-1:0]        wr_code,
  input  logic                     load_n_pin,
  input  logic [1:0]               load_mode,
  input  logic                     single_update,
  input  logic                     data_clr,
  output logic [N_CH*CODE_W-1:0]   dac_codes
);
  logic pin_n_sync;
  logic load;

  assign wr_ready = rst_n;

  dacb_sync #(.STAGES(2), .RST_VAL(1'b1)) u_pin_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (load_n_pin),
    .q_sync  (pin_n_sync)
  );

  dacb_load_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (load_mode),
    .single_req (single_update),
    .pin_n_sync (pin_n_sync),
    .load       (load)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic hit;
    assign hit = wr_valid && (wr_chan == ADDR_W'(i));

    dacb_channel #(.CW(CODE_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (data_clr),
      .wr_hit   (hit),
      .wr_code  (wr_code),
      .load     (load),
      .out_code (dac_codes[i*CODE_W +: CODE_W])
    );

    assert_transparent_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (load_mode == 2'b00 && hit && !data_clr) |=>
        (dac_codes[i*CODE_W +: CODE_W] == $past(wr_code)));
  end
endmodule

// File: tb/dac_bank_dbuf_test.sv
module dac_bank_dbuf_test;
  localparam int PERIOD = 10;
  localparam int NC = 8;
  localparam int W  = 12;

  logic clk = 0;
  logic rst_n = 0;
  logic wr_valid = 0;
  logic wr_ready;
  logic [2:0] wr_chan = 0;
  logic [W-1:0] wr_code = 0;
  logic load_n_pin = 1;
  logic [1:0] load_mode = 2'b01;
  logic single_update = 0;
  logic data_clr = 0;
  logic [NC*W-1:0] dac_codes;

  dac_bank_dbuf uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_chan(wr_chan), .wr_code(wr_code), .load_n_pin(load_n_pin),
    .load_mode(load_mode), .single_update(single_update),
    .data_clr(data_clr), .dac_codes(dac_codes)
  );

  always #(PERIOD/2) clk = ~clk;

  typedef struct {
    int           due;
    int           ch;
    logic [W-1:0] val;
    string        req;
  } exp_t;

  exp_t sb[$];
  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [W-1:0] chan_out(int ch);
    return dac_codes[ch*W +: W];
  endfunction

  task automatic expect_at(int delay, int ch, logic [W-1:0] v, string req);
    exp_t e;
    e.due = cyc + delay; e.ch = ch; e.val = v; e.req = req;
    sb.push_back(e);
  endtask

  // monitor: compares due items at the falling edge
  always @(negedge clk) begin
    for (int k = sb.size() - 1; k >= 0; k--) begin
      if (sb[k].due == cyc) begin
        n_chk++;
        if (chan_out(sb[k].ch) !== sb[k].val) begin
          n_bad++;
          $display("FAIL %s ch%0d cycle %0d: got %h expected %h",
                   sb[k].req, sb[k].ch, cyc, chan_out(sb[k].ch), sb[k].val);
        end
        sb.delete(k);
      end
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write(int ch, logic [W-1:0] v);
    wr_valid = 1; wr_chan = 3'(ch); wr_code = v;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic pin_pulse();
    load_n_pin = 0;
    tick(3);
    load_n_pin = 1;
    tick(3);
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    // R1 reset state
    for (int c = 0; c < NC; c++) expect_at(0, c, '0, "R1");
    n_chk++;
    if (wr_ready !== 1'b1) begin
      n_bad++; $display("FAIL R10 wr_ready got %b expected 1", wr_ready);
    end
    tick(1);

    // R3 latched: write does not reach output
    load_mode = 2'b01;
    expect_at(1, 3, '0, "R3");
    expect_at(4, 3, '0, "R3");
    write(3, 12'hABC);
    tick(4);

    // R4 pin load, due three edges after driving low; R7 clean channel kept
    expect_at(2, 3, '0, "R4");
    expect_at(3, 3, 12'hABC, "R4");
    expect_at(3, 2, '0, "R7");
    pin_pulse();

    // R2 transparent
    load_mode = 2'b00;
    expect_at(1, 5, 12'h123, "R2");
    write(5, 12'h123);
    expect_at(1, 5, 12'h456, "R2");
    write(5, 12'h456);
    tick(2);

    // R8 write while pin load already active (latched mode)
    load_mode = 2'b01;
    load_n_pin = 0;
    tick(3);
    expect_at(1, 1, 12'h555, "R8");
    write(1, 12'h555);
    load_n_pin = 1;
    tick(3);

    // R5 one-shot with held request
    load_mode = 2'b10;
    write(0, 12'h0F0);
    write(6, 12'h777);
    expect_at(0, 0, '0, "R5");
    single_update = 1;
    expect_at(1, 0, 12'h0F0, "R5");
    expect_at(1, 6, 12'h777, "R5");
    tick(1);
    expect_at(1, 0, 12'h0F0, "R5");
    write(0, 12'h111);
    expect_at(2, 0, 12'h0F0, "R5");
    tick(2);
    single_update = 0;
    tick(1);

    // R6 reserved mode: staged only, then pin loads
    load_mode = 2'b11;
    single_update = 1;
    write(7, 12'h999);
    single_update = 0;
    expect_at(2, 7, '0, "R6");
    tick(3);
    expect_at(3, 7, 12'h999, "R6");
    expect_at(3, 0, 12'h111, "R6");
    pin_pulse();

    // R9 clear zeros everything and drops dirty flags
    load_mode = 2'b01;
    write(4, 12'h321);
    data_clr = 1;
    for (int c = 0; c < NC; c++) expect_at(1, c, '0, "R9");
    tick(1);
    data_clr = 0;
    tick(1);
    expect_at(3, 4, '0, "R9");
    expect_at(3, 7, '0, "R9");
    pin_pulse();

    tick(3);
    n_chk++;
    if (sb.size() != 0) begin
      n_bad++; $display("FAIL scoreboard: %0d left expected 0", sb.size());
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(PERIOD * 5000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule